// File: doc/BRIEF.md
# Two-Coin Vending Controller

This block is a Moore state machine that sells one item priced at two coins of equal value. It takes one coin-present level that has already been debounced and synchronised to `clk_i`. For each coin it raises an accept indication, then waits for the coin line to drop, and then pauses for one fixed step. When the second coin has been handled, it raises a dispense strobe for one step and returns to its start state.

The machine runs on the system clock. It advances only on edges where the single-cycle `tick_i` enable is high, so a slow step rate needs no derived clock. Outputs depend only on the current state. The state code is also driven out so that the surrounding logic can observe the sequence.

Top module: `vend_ctrl`

## Requirements
- R1: When `rst_ni` is driven low, the state goes at once, without waiting for a clock edge, to INIT (code 0), and `accept_o` and `dispense_o` are both 0. The state codes are INIT=0, IDLE=1, COIN1=2, REL1=3, ARM2=4, COIN2=5, REL2=6, VEND=7.
- R2: On a tick, INIT moves to IDLE whatever the value of `coin_i`.
- R3: IDLE stays in IDLE on a tick while `coin_i` is 0, and moves to COIN1 on a tick with `coin_i` at 1.
- R4: COIN1 stays in COIN1 on every tick while `coin_i` is 1, and moves to REL1 on a tick with `coin_i` at 0. REL1 moves to ARM2 on the next tick whatever the value of `coin_i`.
- R5: ARM2 stays in ARM2 on a tick while `coin_i` is 0, and moves to COIN2 on a tick with `coin_i` at 1.
- R6: COIN2 stays in COIN2 while `coin_i` is 1, and moves to REL2 on a tick with `coin_i` at 0. REL2 then moves to VEND, and VEND moves to INIT, each on the next tick and each whatever the value of `coin_i`.
- R7: `accept_o` is 1 exactly in COIN1 and COIN2, and 0 in every other state.
- R8: `dispense_o` is 1 only in VEND, so it lasts exactly one enabled step, and it is never 1 at the same time as `accept_o`.
- R9: On a clock edge with `tick_i` low, the state and both outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle step enable |
| coin_i | input | 1 | Coin present, already debounced and synchronous |
| accept_o | output | 1 | Coin accepted indication |
| dispense_o | output | 1 | Dispense strobe |
| state_o | output | 3 | Current state code |

## Verification
The assertions assume that `coin_i` and `tick_i` are synchronous to `clk_i` and change only between edges. They also assume that a step is marked by `tick_i` alone, with no relation to how `coin_i` moves. The stimulus changes both inputs two nanoseconds after a rising edge and holds them for the rest of the cycle. It mixes ticked and unticked cycles and includes coin holds that last many ticks. Reset is the only input pulled low in mid-cycle, because the state is meant to respond to it at once.

// File: rtl/vend_pkg.sv
package vend_pkg;
  localparam int unsigned STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_INIT  = 3'd0,
    ST_IDLE  = 3'd1,
    ST_COIN1 = 3'd2,
    ST_REL1  = 3'd3,
    ST_ARM2  = 3'd4,
    ST_COIN2 = 3'd5,
    ST_REL2  = 3'd6,
    ST_VEND  = 3'd7
  } vend_state_e;
endpackage

// File: rtl/vend_next.sv
module vend_next
  import vend_pkg::*;
(
  input  vend_state_e state_i,
  input  logic        coin_i,
  output vend_state_e next_o
);
  always_comb begin
    next_o = state_i;
    unique case (state_i)
      ST_INIT:  next_o = ST_IDLE;
      ST_IDLE:  next_o = coin_i ? ST_COIN1 : ST_IDLE;
      ST_COIN1: next_o = coin_i ? ST_COIN1 : ST_REL1;
      ST_REL1:  next_o = ST_ARM2;
      ST_ARM2:  next_o = coin_i ? ST_COIN2 : ST_ARM2;
      ST_COIN2: next_o = coin_i ? ST_COIN2 : ST_REL2;
      ST_REL2:  next_o = ST_VEND;
      ST_VEND:  next_o = ST_INIT;
      default:  next_o = ST_INIT;
    endcase
  end
endmodule

// File: rtl/vend_outputs.sv
module vend_outputs
  import vend_pkg::*;
(
  input  vend_state_e state_i,
  output logic        accept_o,
  output logic        dispense_o
);
  always_comb begin
    accept_o   = 1'b0;
    dispense_o = 1'b0;
    case (state_i)
      ST_COIN1, ST_COIN2: accept_o   = 1'b1;
      ST_VEND:            dispense_o = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
  import vend_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               coin_i,
  output logic               accept_o,
  output logic               dispense_o,
  output logic [STATE_W-1:0] state_o
);
  vend_state_e state_q, state_d;

  vend_next i_next (
    .state_i (state_q),
    .coin_i  (coin_i),
    .next_o  (state_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= ST_INIT;
    else if (tick_i) state_q <= state_d;
  end

  vend_outputs i_out (
    .state_i    (state_q),
    .accept_o   (accept_o),
    .dispense_o (dispense_o)
  );

  assign state_o = state_q;

  assert_hold_no_tick_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(state_q));

  assert_init_to_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && state_q == ST_INIT) |=> state_q == ST_IDLE);

  assert_coin1_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && coin_i && state_q == ST_COIN1) |=> state_q == ST_COIN1);

  assert_rel1_to_arm_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && state_q == ST_REL1) |=> state_q == ST_ARM2);

  assert_vend_to_init_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && state_q == ST_VEND) |=> state_q == ST_INIT);

  assert_dispense_one_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && dispense_o) |=> !dispense_o);

  assert_excl_outputs_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(accept_o && dispense_o));

  assert_accept_after_coin_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(accept_o) |-> $past(coin_i) && $past(tick_i));
endmodule

// File: tb/test_vend_ctrl.sv
module test_vend_ctrl;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick = 1'b0;
  logic       coin = 1'b0;
  logic       accept, dispense;
  logic [2:0] state;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  vend_ctrl i_vend_ctrl (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .coin_i     (coin),
    .accept_o   (accept),
    .dispense_o (dispense),
    .state_o    (state)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input int st, input int acc, input int dis);
    chk({req, " state"}, state, st);
    chk({req, " accept"}, accept, acc);
    chk({req, " dispense"}, dispense, dis);
  endtask

  // drive inputs for one cycle, sample 2 ns after the edge
  task automatic cyc(input logic t, input logic c);
    tick = t;
    coin = c;
    @(posedge clk);
    #2;
  endtask

  task automatic t_reset;
    rst_ni = 1'b0;
    #3;
    chk_all("R1 reset", 0, 0, 0);
    @(posedge clk);
    #2 rst_ni = 1'b1;
    cyc(0, 0);
    chk_all("R1 after release", 0, 0, 0);
  endtask

  task automatic t_purchase;
    cyc(1, 1); chk_all("R2 init->idle", 1, 0, 0);
    cyc(1, 0); chk_all("R3 idle wait", 1, 0, 0);
    cyc(0, 1); chk_all("R9 no tick", 1, 0, 0);
    cyc(1, 1); chk_all("R3 R7 coin1", 2, 1, 0);
    cyc(1, 0); chk_all("R4 rel1", 3, 0, 0);
    cyc(1, 0); chk_all("R4 arm2", 4, 0, 0);
    cyc(1, 0); chk_all("R5 arm2 wait", 4, 0, 0);
    cyc(1, 1); chk_all("R5 R7 coin2", 5, 1, 0);
    cyc(1, 0); chk_all("R6 rel2", 6, 0, 0);
    cyc(1, 1); chk_all("R6 R8 vend", 7, 0, 1);
    cyc(0, 0); chk_all("R9 vend held", 7, 0, 1);
    cyc(1, 1); chk_all("R6 R8 back to init", 0, 0, 0);
  endtask

  task automatic t_long_hold;
    cyc(1, 0); chk_all("R2 idle", 1, 0, 0);
    cyc(1, 1); chk_all("R3 coin1", 2, 1, 0);
    for (int i = 0; i < 6; i++) begin
      cyc(1, 1);
      chk_all("R4 hold coin1", 2, 1, 0);
    end
    cyc(1, 0); chk_all("R4 rel1", 3, 0, 0);
    cyc(1, 1); chk_all("R4 rel1 ignores coin", 4, 0, 0);
    cyc(1, 1); chk_all("R5 coin2", 5, 1, 0);
    for (int i = 0; i < 4; i++) begin
      cyc(1, 1);
      chk_all("R6 hold coin2", 5, 1, 0);
    end
  endtask

  task automatic t_mid_reset;
    #1 rst_ni = 1'b0;
    #1;
    chk_all("R1 async mid reset", 0, 0, 0);
    @(posedge clk);
    #2 rst_ni = 1'b1;
    cyc(1, 0); chk_all("R2 restart idle", 1, 0, 0);
    cyc(1, 1); chk_all("R3 restart coin1", 2, 1, 0);
  endtask

  initial begin
    t_reset();
    t_purchase();
    t_long_hold();
    t_mid_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule